// File: doc/BRIEF.md
# Split-Count Pulse-Width Modulator

A single-channel pulse-width modulator whose waveform is given as two separate counts of input-clock cycles: the number of cycles spent high and the number of cycles spent low. Both counts are written through a simple 32-bit register port into shadow registers. The running waveform keeps using its active copies until software writes the control register with the load bit set. That write copies both shadows into the active counts at once and restarts the period at its high phase. Software can therefore retune both counts and have them take effect together.

The output toggles only when both the run bit and the drive bit of the control register are set. Writing zero to the control register stops the waveform and holds the output low. Reads are combinational from the address: the control register, both shadow counts, and zero for any unmapped offset.

Top module: `cyc_pwm`

## Requirements
- R1: After reset the output is low and the control register and both count registers read as zero.
- R2: The control register is at byte offset 0x00, the low-count register at 0x18 and the high-count register at 0x1C. Each count register reads back the last 32-bit value written to it.
- R3: A write to a count register changes only its shadow. The waveform in progress continues unchanged until the next control write with the load bit set.
- R4: The output can be high only while control bit 0 (run) and bit 14 (drive) are both set. After a control write that clears either bit, the output is low from the cycle after that write.
- R5: While running, each period holds the output high for the active high count and then low for the active low count. The period is their sum. Cycle 0 of a period is the cycle just after the control write that started it.
- R6: A control write with bit 5 (load) set copies both shadow counts into the active counts and restarts at cycle 0 of the high phase. Bit 5 reads back as zero. A control write without bit 5 leaves the active counts and the period position unchanged.
- R7: An active high count of zero gives a constant low output, and that includes both counts being zero. A nonzero high count with a zero low count gives a constant high output. Counts up to 0xFFFFFFFF do not overflow the period.
- R8: The control register keeps bits 0, 2, 9, 10 and 14 (mask 0x00004605), and all other bits read as zero. Bits 2, 9 and 10 have no effect on the output.
- R9: A write to any offset other than 0x00, 0x18 or 0x1C changes no register and no output. A read from such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, the unit of both counts |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
Read data is due in the same cycle as the address, so the bench sets the address with the strobe low and compares a moment later. A register write takes effect at the clock edge on which the strobe is sampled, and the output for period cycle 0 is visible right after that edge, because the output decodes registered state with no further stage. The bench advances its own model of the period position at each edge and samples the output 2 ns after every rising edge, so each cycle is compared exactly once at a settled point. Shadow writes during a run, control writes without load, and unmapped writes are placed in the middle of running periods, so any disturbance shows as a mismatch in the following cycles.

// File: rtl/cyc_pwm_pkg.sv
`timescale 1ns/1ps
package cyc_pwm_pkg;
  parameter int CNT_W  = 32;
  parameter int POS_W  = CNT_W + 1;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_LOW  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFS_HIGH = ADDR_W'(8'h1C);

  localparam int B_RUN   = 0;
  localparam int B_MODE  = 2;
  localparam int B_LOAD  = 5;
  localparam int B_TRIG  = 9;
  localparam int B_INV   = 10;
  localparam int B_DRIVE = 14;

  localparam logic [DATA_W-1:0] CTRL_KEEP =
    (DATA_W'(1) << B_RUN) | (DATA_W'(1) << B_MODE) | (DATA_W'(1) << B_TRIG) |
    (DATA_W'(1) << B_INV) | (DATA_W'(1) << B_DRIVE);

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [POS_W-1:0] pos_t;

  // Full period length; one extra bit so that two maximal counts fit.
  function automatic pos_t period_of(cnt_t hi, cnt_t lo);
    return {1'b0, hi} + {1'b0, lo};
  endfunction

  // Position of the next cycle inside a period of length per (0 stays at 0).
  function automatic pos_t pos_advance(pos_t p, pos_t per);
    pos_t n;
    n = p + POS_W'(1);
    if (n >= per) return '0;
    return n;
  endfunction

  // Output level for a given position: high while inside the high phase.
  function automatic logic level_at(logic run, pos_t p, cnt_t hi);
    return run && (p < {1'b0, hi});
  endfunction
endpackage

// File: rtl/cyc_pwm_regs.sv
`timescale 1ns/1ps
module cyc_pwm_regs
  import cyc_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output cnt_t              act_hi,
  output cnt_t              act_lo,
  output logic              run,
  output logic              load_evt
);
  logic [DATA_W-1:0] ctrl_q;
  cnt_t sh_hi, sh_lo;
  logic ctrl_wr, low_wr, high_wr;

  assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
  assign low_wr   = bus_wr && (bus_addr == OFS_LOW);
  assign high_wr  = bus_wr && (bus_addr == OFS_HIGH);
  assign load_evt = ctrl_wr && bus_wdata[B_LOAD];
  assign run      = ctrl_q[B_RUN] && ctrl_q[B_DRIVE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sh_hi  <= '0;
      sh_lo  <= '0;
      act_hi <= '0;
      act_lo <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (low_wr)  sh_lo  <= bus_wdata[CNT_W-1:0];
      if (high_wr) sh_hi  <= bus_wdata[CNT_W-1:0];
      if (load_evt) begin
        act_hi <= sh_hi;
        act_lo <= sh_lo;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_LOW:  bus_rdata = DATA_W'(sh_lo);
      OFS_HIGH: bus_rdata = DATA_W'(sh_hi);
      default:  bus_rdata = '0;
    endcase
  end

  // R3: active counts move only on a control write
  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ($stable(act_hi) && $stable(act_lo)));

  // R6: a load copies the shadows as they stood before the edge
  p_load_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (act_hi == $past(sh_hi) && act_lo == $past(sh_lo)));

  // R9: unmapped writes leave the control register alone
  p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !ctrl_wr && !low_wr && !high_wr) |=> $stable(ctrl_q));
endmodule

// File: rtl/cyc_pwm_gen.sv
`timescale 1ns/1ps
module cyc_pwm_gen
  import cyc_pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load_evt,
  input  cnt_t act_hi,
  input  cnt_t act_lo,
  output logic pwm_out
);
  pos_t pos_q, period;

  assign period  = period_of(act_hi, act_lo);
  assign pwm_out = level_at(run, pos_q, act_hi);

  always_ff @(posedge clk) begin
    if (!rst_n)        pos_q <= '0;
    else if (load_evt) pos_q <= '0;
    else if (!run)     pos_q <= '0;
    else               pos_q <= pos_advance(pos_q, period);
  end

  // R4: no high output without both gate bits
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out |-> run);

  // R7: zero high count never drives high
  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hi == '0) |-> !pwm_out);

  // R6: a load restarts the period
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (pos_q == '0));

  // R5: the position stays inside a nonzero period
  p_pos_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (pos_q < period));
endmodule

// File: rtl/cyc_pwm.sv
`timescale 1ns/1ps
module cyc_pwm
  import cyc_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  cnt_t act_hi, act_lo;
  logic run, load_evt;

  cyc_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_hi(act_hi),
    .act_lo(act_lo), .run(run), .load_evt(load_evt)
  );

  cyc_pwm_gen u_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .load_evt(load_evt),
    .act_hi(act_hi), .act_lo(act_lo), .pwm_out(pwm_out)
  );
endmodule

// File: tb/cyc_pwm_tb_top.sv
`timescale 1ns/1ps
module cyc_pwm_tb_top;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic pwm_out;
  int nvec = 0, nbad = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_ctrl = 0, m_shi = 0, m_slo = 0, m_hi = 0, m_lo = 0;
  logic [32:0] m_pos = 0;
  logic m_run = 0;
  string cur_tag = "R5";

  cyc_pwm dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #4 clk = ~clk;

  function automatic logic exp_level();
    return m_run && (m_pos < {1'b0, m_hi});
  endfunction

  function automatic logic [32:0] next_pos(logic [32:0] p);
    logic [32:0] per;
    per = {1'b0, m_hi} + {1'b0, m_lo};
    if (per == 0 || p + 1 == per) return 0;
    return p + 1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic ld;
    ld = 0;
    if (m_run) m_pos = next_pos(m_pos); else m_pos = 0;
    if (bus_wr) begin
      case (bus_addr)
        8'h00: begin
          m_ctrl = bus_wdata & 32'h0000_4605;
          ld = bus_wdata[5];
          m_run = m_ctrl[0] && m_ctrl[14];
        end
        8'h18: m_slo = bus_wdata;
        8'h1C: m_shi = bus_wdata;
        default: ;
      endcase
    end
    if (ld) begin m_hi = m_shi; m_lo = m_slo; m_pos = 0; end
    if (!m_run) m_pos = 0;
    @(posedge clk); #2;
    bus_wr = 0;
    check(cur_tag, {31'b0, pwm_out}, {31'b0, exp_level()});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    tick();
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: reset state
    check("R1 out", {31'b0, pwm_out}, 0);
    rd("R1 ctrl", 8'h00, 0); rd("R1 low", 8'h18, 0); rd("R1 high", 8'h1C, 0);

    // R2/R5: basic pattern 3 high, 2 low
    cur_tag = "R5";
    wr(8'h18, 2); wr(8'h1C, 3);
    rd("R2 low rb", 8'h18, 2); rd("R2 high rb", 8'h1C, 3);
    wr(8'h00, 32'h0000_4021);
    rd("R6 load bit reads 0", 8'h00, 32'h0000_4001);
    run_cycles(12);

    // R3: shadow writes mid-run do not disturb
    cur_tag = "R3";
    wr(8'h18, 7); run_cycles(3); wr(8'h1C, 1); run_cycles(9);
    // R6: control write without load keeps position and counts
    cur_tag = "R6";
    wr(8'h00, 32'h0000_4605); run_cycles(8);
    rd("R8 ctrl keep", 8'h00, 32'h0000_4605);
    wr(8'h00, 32'h0000_4021); run_cycles(10);

    // R9: unmapped offsets
    cur_tag = "R9";
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h20, 32'h1234_5678); wr(8'h1B, 32'h5);
    rd("R9 read 0x04", 8'h04, 0); rd("R9 read 0x20", 8'h20, 0);
    rd("R9 ctrl intact", 8'h00, 32'h0000_4001);
    rd("R9 high intact", 8'h1C, 1);
    run_cycles(6);

    // R4: clearing control stops output
    cur_tag = "R4";
    wr(8'h00, 0); run_cycles(5);
    wr(8'h00, 32'h0000_0021); run_cycles(4);
    wr(8'h00, 32'h0000_4020); run_cycles(4);
    wr(8'h00, 32'h0000_4001); run_cycles(9);

    // R7: corner counts
    cur_tag = "R7";
    wr(8'h18, 0); wr(8'h1C, 0); wr(8'h00, 32'h0000_4021); run_cycles(6);
    wr(8'h18, 4); wr(8'h00, 32'h0000_4021); run_cycles(8);
    wr(8'h18, 0); wr(8'h1C, 5); wr(8'h00, 32'h0000_4021); run_cycles(8);
    check("R7 const high", {31'b0, pwm_out}, 1);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    rd("R2 full width", 8'h1C, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_4021); run_cycles(20);

    // random mix, R5 and R8
    for (int k = 0; k < 40; k++) begin
      logic [31:0] c;
      cur_tag = "R5";
      wr(8'h18, $urandom_range(0, 9));
      wr(8'h1C, $urandom_range(0, 9));
      c = $urandom & 32'hFFFF_BFDE;
      if ($urandom_range(0, 3) != 0) c = c | 32'h0000_4001;
      if ($urandom_range(0, 3) != 0) c = c | 32'h0000_0020;
      cur_tag = "R8";
      wr(8'h00, c);
      rd("R8 ctrl mask", 8'h00, c & 32'h0000_4605);
      run_cycles(24);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule